// File: doc/BRIEF.md
# Power Domain Switch Handshake Controller

This controller takes a single command to switch one of ten peripheral power domains on or off. It turns the domain selector and the direction flag into a single request bit for an external power sequencer. Before that request goes out, it raises a global enable. It then checks the sequencer's acknowledge word and two status words at a fixed interval. It stops when the chosen domain reports the requested state, or when too many checks have failed.

A command starts with a one-cycle start strobe that carries a domain index and an on/off flag. At the end of the operation the controller clears both the request word and the enable. In that same cycle it pulses done, with the error flag already valid. The error flag then holds its value until the next accepted command. The poll interval is counted in clock cycles and is a parameter, so a fast bench can shrink it. The limit on failed checks is also a parameter.

Top module: `pwr_dom_ctrl`

## Requirements
- R1: After reset, req_o is zero and en_o, done_o and err_o are low.
- R2: For a valid domain index n (0 to 9), req_o carries exactly bit n when on_i was high at start and exactly bit n+10 when it was low; the remaining bits of req_o are zero.
- R3: en_o rises in the cycle after start is accepted, one cycle before req_o becomes nonzero, and stays high while the request is out; err_o reads low in that cycle.
- R4: A check succeeds only when ack_i ANDed with req_o is nonzero, and bit p of sta_i equals the latched on flag, and bit p of sta2_i equals it too. The position p depends on the index: 0→7, 1→21, 2→5, 3→3, 4→20, 5→24, 6→23, 7→22, 8→4, 9→25.
- R5: When an operation ends, req_o returns to zero and en_o falls in the same cycle as the done_o pulse.
- R6: The first check happens in the first cycle req_o is nonzero. After a failed check, the next check happens TICK_CYCLES cycles later, so success at check j produces done_o 3+j*TICK_CYCLES cycles after the start edge.
- R7: If MAX_POLLS+1 consecutive checks fail, the operation ends with err_o high. done_o lasts one cycle. err_o holds until the next accepted start, which clears it.
- R8: A domain index of 10 to 15 gives done_o and err_o high in the next cycle. No request is issued and en_o stays low.
- R9: A start strobe that arrives while an operation is in progress is ignored; req_o and the completion time do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe, accepted when idle |
| dom_id_i | input | ID_W | Domain index |
| on_i | input | 1 | 1 = switch on, 0 = switch off |
| ack_i | input | DAT_W | Acknowledge word from the sequencer |
| sta_i | input | DAT_W | Primary status word |
| sta2_i | input | DAT_W | Secondary status word |
| req_o | output | 2*10 | One-hot request word |
| en_o | output | 1 | Global control enable |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Failure flag, held until next start |

## Verification
Every index from 0 to 15 is tried in both directions. For each one, the bench drives five input patterns:
- Every condition true at once. This pins down the request bit, the status bit position and the minimum latency.
- Acknowledge missing the request bit only.
- Primary status bit inverted.
- Secondary status bit inverted.
- Conditions that become true just before the third check.

The three single-fault patterns show that each leg of the success condition is required on its own. Status and acknowledge words carry the opposite value in every other bit, so selecting the wrong position is caught. The late pattern measures the poll spacing to the cycle, and it also carries a stray start strobe while the controller is busy.

// File: rtl/pwr_dom_pkg.sv
package pwr_dom_pkg;
  localparam int unsigned NUM_DOM   = 10;
  localparam int unsigned POS_W     = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_POLL} state_e;

  // status bit position per domain index
  function automatic logic [POS_W-1:0] sta_pos(input int unsigned idx);
    case (idx)
      0: sta_pos = 5'd7;
      1: sta_pos = 5'd21;
      2: sta_pos = 5'd5;
      3: sta_pos = 5'd3;
      4: sta_pos = 5'd20;
      5: sta_pos = 5'd24;
      6: sta_pos = 5'd23;
      7: sta_pos = 5'd22;
      8: sta_pos = 5'd4;
      9: sta_pos = 5'd25;
      default: sta_pos = 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/pwr_dom_map.sv
module pwr_dom_map #(
  parameter int unsigned ID_W    = 4,
  parameter int unsigned NUM_DOM = pwr_dom_pkg::NUM_DOM,
  localparam int unsigned REQ_W  = 2 * NUM_DOM
) (
  input  logic [ID_W-1:0]                  id_i,
  input  logic                             on_i,
  output logic                             valid_o,
  output logic [REQ_W-1:0]                 req_o,
  output logic [pwr_dom_pkg::POS_W-1:0]    pos_o
);
  logic [NUM_DOM-1:0] sel;

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_sel
    assign sel[g] = (id_i == ID_W'(g));
  end

  assign valid_o = |sel;
  assign req_o   = on_i ? {{NUM_DOM{1'b0}}, sel} : {sel, {NUM_DOM{1'b0}}};

  always_comb begin
    pos_o = '0;
    for (int i = 0; i < NUM_DOM; i++) begin
      if (sel[i]) pos_o = pwr_dom_pkg::sta_pos(i);
    end
  end
endmodule

// File: rtl/pwr_dom_pacer.sv
module pwr_dom_pacer #(
  parameter int unsigned TICK_CYCLES = 1000,
  parameter int unsigned MAX_POLLS   = 10000,
  localparam int unsigned TW = $clog2(TICK_CYCLES + 1),
  localparam int unsigned PW = $clog2(MAX_POLLS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic miss_i,
  output logic due_o,
  output logic expire_o
);
  logic [TW-1:0] wait_q;
  logic [PW-1:0] miss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
    end else if (arm_i) begin
      wait_q <= '0;
    end else if (miss_i) begin
      wait_q <= TW'(TICK_CYCLES - 1);
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_q <= '0;
    end else if (arm_i) begin
      miss_q <= '0;
    end else if (miss_i && !expire_o) begin
      miss_q <= miss_q + 1'b1;
    end
  end

  assign due_o    = (wait_q == '0);
  assign expire_o = (miss_q == PW'(MAX_POLLS));
endmodule

// File: rtl/pwr_dom_ctrl.sv
module pwr_dom_ctrl #(
  parameter int unsigned ID_W        = 4,
  parameter int unsigned DAT_W       = 32,
  parameter int unsigned TICK_CYCLES = 1000,
  parameter int unsigned MAX_POLLS   = 10000,
  localparam int unsigned REQ_W      = 2 * pwr_dom_pkg::NUM_DOM
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ID_W-1:0]  dom_id_i,
  input  logic             on_i,
  input  logic [DAT_W-1:0] ack_i,
  input  logic [DAT_W-1:0] sta_i,
  input  logic [DAT_W-1:0] sta2_i,
  output logic [REQ_W-1:0] req_o,
  output logic             en_o,
  output logic             done_o,
  output logic             err_o
);
  import pwr_dom_pkg::*;

  state_e            st_q;
  logic              map_valid;
  logic [REQ_W-1:0]  map_req;
  logic [POS_W-1:0]  map_pos;
  logic [REQ_W-1:0]  pend_q, req_q;
  logic [POS_W-1:0]  pos_q;
  logic              on_q, en_q, done_q, err_q;
  logic              due, expire, hit, miss, arm;

  pwr_dom_map #(.ID_W(ID_W)) u_map (
    .id_i   (dom_id_i),
    .on_i   (on_i),
    .valid_o(map_valid),
    .req_o  (map_req),
    .pos_o  (map_pos)
  );

  assign arm  = (st_q == ST_ARM);
  assign hit  = (|(ack_i[REQ_W-1:0] & req_q)) &&
                (sta_i[pos_q] == on_q) && (sta2_i[pos_q] == on_q);
  assign miss = (st_q == ST_POLL) && due && !hit;

  pwr_dom_pacer #(.TICK_CYCLES(TICK_CYCLES), .MAX_POLLS(MAX_POLLS)) u_pacer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm),
    .miss_i  (miss),
    .due_o   (due),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      req_q  <= '0;
      pos_q  <= '0;
      on_q   <= 1'b0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            err_q <= 1'b0;
            if (!map_valid) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else begin
              pend_q <= map_req;
              pos_q  <= map_pos;
              on_q   <= on_i;
              en_q   <= 1'b1;
              st_q   <= ST_ARM;
            end
          end
        end
        ST_ARM: begin
          req_q <= pend_q;
          st_q  <= ST_POLL;
        end
        ST_POLL: begin
          if (due && (hit || expire)) begin
            req_q  <= '0;
            en_q   <= 1'b0;
            done_q <= 1'b1;
            err_q  <= !hit;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o  = req_q;
  assign en_o   = en_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/pwr_dom_chk.sv
module pwr_dom_chk #(
  parameter int unsigned REQ_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [REQ_W-1:0] req_o,
  input logic             en_o,
  input logic             done_o,
  input logic             err_o
);
  AST_REQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_o)); // R2

  AST_REQ_UNDER_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o != '0) |-> en_o); // R3

  AST_EN_LEADS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o != '0) |-> $past(en_o)); // R3

  AST_END_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (req_o == '0) && !en_o); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_ERR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_o) |-> (done_o || $past(start_i))); // R7
endmodule

bind pwr_dom_ctrl pwr_dom_chk #(.REQ_W(REQ_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .req_o  (req_o),
  .en_o   (en_o),
  .done_o (done_o),
  .err_o  (err_o)
);

// File: tb/pwr_dom_ctrl_tb.sv
module pwr_dom_ctrl_tb_top;
  localparam int unsigned T    = 3;
  localparam int unsigned MAXP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  dom_id = '0;
  logic        on = 1'b0;
  logic [31:0] ack = '0, sta = '0, sta2 = '0;
  logic [19:0] req;
  logic        en, done, err;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwr_dom_ctrl #(.TICK_CYCLES(T), .MAX_POLLS(MAXP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dom_id_i(dom_id), .on_i(on),
    .ack_i(ack), .sta_i(sta), .sta2_i(sta2),
    .req_o(req), .en_o(en), .done_o(done), .err_o(err)
  );

  function automatic int exp_pos(input int n);
    case (n)
      0: return 7;   1: return 21;  2: return 5;  3: return 3;  4: return 20;
      5: return 24;  6: return 23;  7: return 22; 8: return 4;  9: return 25;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s id=%0d on=%0d act=0x%0h exp=0x%0h t=%0t", tag, dom_id, on, act, exp, $time);
    end
  endtask

  // mode: 0 all good, 1 ack wrong, 2 sta wrong, 3 sta2 wrong, 4 good late
  task automatic drive_inputs(input int n, input bit o, input int mode, input bit good);
    logic [31:0] rb, sb;
    rb = 32'(1) << (o ? n : n + 10);
    sb = 32'(1) << exp_pos(n);
    ack  = rb;
    sta  = o ? sb : ~sb;
    sta2 = o ? sb : ~sb;
    if (!good) begin
      case (mode)
        1: ack  = ~rb;
        2: sta  = ~sta;
        3: sta2 = ~sta2;
        default: begin ack = ~rb; sta = ~sta; end
      endcase
    end
  endtask

  task automatic run_case(input int n, input bit o, input int mode);
    int done_at;
    logic [19:0] exp_req;
    exp_req = 20'(1) << (o ? n : n + 10);
    @(negedge clk);
    dom_id = 4'(n);
    on     = o;
    drive_inputs(n, o, mode, mode == 0);
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    if (n > 9) begin
      chk(done && err, "R8 done/err", {done, err}, 2'b11);
      chk(req == 0 && !en, "R8 no request", {en, req}, 0);
      @(negedge clk);
      chk(!done && err, "R7 err held after pulse", {done, err}, 2'b01);
      chk(req == 0 && !en, "R8 still idle", {en, req}, 0);
      return;
    end
    chk(en && req == 0, "R3 enable leads request", {en, req}, 21'h100000);
    chk(!err && !done, "R7 err cleared by start", {done, err}, 0);
    @(negedge clk);
    chk(req == exp_req, "R2 request bit", req, exp_req);
    chk(en, "R3 enable held", en, 1);
    done_at = (mode == 0) ? 3 : (mode == 4) ? 3 + 2 * T : 3 + MAXP * T;
    if (mode == 4) begin
      start  = 1'b1;
      dom_id = 4'((n + 1) % 10);
      on     = ~o;
    end
    for (int k = 3; k < done_at; k++) begin
      @(negedge clk);
      if (mode == 4 && k == 3) begin
        start  = 1'b0;
        dom_id = 4'(n);
        on     = o;
        chk(req == exp_req, "R9 busy start ignored", req, exp_req);
      end
      if (mode == 4 && k == 2 + 2 * T) drive_inputs(n, o, mode, 1'b1);
      chk(!done, "R6 no early done", done, 0);
    end
    @(negedge clk);
    chk(done, "R6 done timing", done, 1);
    chk(err == (mode >= 1 && mode <= 3), mode inside {1,2,3} ? "R7 timeout error" : "R4 success",
        err, (mode >= 1 && mode <= 3));
    chk(req == 0 && !en, "R5 cleared at end", {en, req}, 0);
    @(negedge clk);
    chk(!done, "R7 done single cycle", done, 0);
    chk(err == (mode >= 1 && mode <= 3), "R7 err held", err, (mode >= 1 && mode <= 3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req == 0 && !en && !done && !err, "R1 reset state", {en, done, err, req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req == 0 && !en && !done && !err, "R1 after release", {en, done, err, req}, 0);
    for (int n = 0; n < 16; n++) begin
      for (int o = 0; o < 2; o++) begin
        if (n > 9) run_case(n, o[0], 0);
        else
          for (int m = 0; m < 5; m++) run_case(n, o[0], m);
      end
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule